// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Model

This block is a synthesizable, reduced-depth model of a synchronous SRAM with a shared data bus that moves data on both halves of its input clock. Each access carries two words. A new access begins when the active-low load strobe is seen low on a rising edge of K. At that edge the read/write flag and the word address are captured. The two K phases are modelled with one rising-edge clock at twice the K rate. An internal phase bit marks which edges stand for K rising and which stand for K-bar rising.

On a write, the first data word and its two active-low byte selects are taken on the K edge that loads the access. The second word and its selects are taken on the K-bar edge that follows. On a read, the first word is driven one full K cycle after the load and the second word half a cycle later, with the bus output enable raised for exactly those two beats. The low address bit seeds a burst counter: the second beat goes to the other word of the same aligned pair. Loads may arrive on every K cycle, so bursts run back to back with no gap.

Top module: `burst2_ddr_sram`

## Requirements
- R1: While `rstN` is low and after it is released, `dqOe` is low and no access is pending. A reset asserted between a read load and its data cancels that read.
- R2: An access is started only when `loadN` is low at a K edge. With `loadN` high, no word is written and no read beat is driven, whatever the other inputs are.
- R3: `readNotWrite` sampled with the load selects the direction: 1 is a read, 0 is a write.
- R4: A write stores beat 0 from `dqIn` and `byteWeN` on the loading K edge, and beat 1 from the same inputs on the next K-bar edge.
- R5: `byteWeN` is active low. Bit 0 gates data bits 8:0 and bit 1 gates bits 17:9. A byte whose select is high keeps its stored value.
- R6: Beat 0 uses the loaded address. Beat 1 uses that address with bit 0 inverted, so the burst wraps inside its aligned pair.
- R7: A read loaded at K edge n drives beat 0 on `dqOut` from K edge n+1 and beat 1 from the K-bar edge that follows it.
- R8: `dqOe` is high exactly during the two beats of each read and low otherwise. It changes only at K edges.
- R9: Loads on consecutive K cycles are all served with no idle beat. A read loaded right after a write to the same pair returns the newly written data.
- R10: The first `clk2x` edge after `rstN` is released is a K edge, and K and K-bar edges alternate from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the K rate; even edges after reset are K rising, odd edges are K-bar rising |
| rstN | input | 1 | Asynchronous active-low reset |
| loadN | input | 1 | Active-low load strobe, sampled on K edges |
| readNotWrite | input | 1 | Access direction: 1 read, 0 write |
| addr | input | AW (8) | Word address of the burst |
| dqIn | input | 18 | Write data for the current beat |
| byteWeN | input | 2 | Active-low byte write selects for the current beat |
| dqOut | output | 18 | Read data driven onto the shared bus |
| dqOe | output | 1 | Bus output enable; the pad is high-impedance when low |

## Verification
The checks assume that the inputs are stable around each `clk2x` rising edge. They also assume that `rstN` is released so that the phase counted by the bench starts on a K edge. They do not model undefined array contents. The stimulus changes every input only at falling edges of `clk2x`, releases reset at a falling edge, and reads only words it has already written. `readNotWrite`, `addr`, `dqIn` and `byteWeN` are still driven with arbitrary values while `loadN` is high, so that the ignore rule is exercised.

// File: rtl/burst2_pkg.sv
package burst2_pkg;

  // width of one independently maskable byte lane
  localparam int LANE_W = 9;

  // per-edge strobes from control to datapath
  typedef struct packed {
    logic wrEn;  // store the current beat
    logic rdEn;  // load the output register from the array
  } beatStrobe_t;

endpackage

// File: rtl/burst2_ctrl.sv
module burst2_ctrl
  import burst2_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk2x,
  input  logic          rstN,
  input  logic          loadN,
  input  logic          readNotWrite,
  input  logic [AW-1:0] addr,
  output beatStrobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          kSlot
);

  logic          phase;      // 0: next edge is K, 1: next edge is K-bar
  logic          loadHit;
  logic          pendRd;     // read loaded, waiting one K cycle
  logic [AW-1:0] pendAddr;
  logic          burstRd;    // read whose beat 1 is due on the K-bar edge
  logic [AW-1:0] burstAddr;
  logic          wrPend;     // write whose beat 1 is due on the K-bar edge
  logic [AW-1:0] wrBase;

  function automatic logic [AW-1:0] pairMate(input logic [AW-1:0] base);
    return {base[AW-1:1], ~base[0]};
  endfunction

  assign kSlot   = ~phase;
  assign loadHit = kSlot & ~loadN;

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      phase     <= 1'b0;
      pendRd    <= 1'b0;
      pendAddr  <= '0;
      burstRd   <= 1'b0;
      burstAddr <= '0;
      wrPend    <= 1'b0;
      wrBase    <= '0;
    end else begin
      phase <= ~phase;
      if (kSlot) begin
        pendRd    <= loadHit & readNotWrite;
        wrPend    <= loadHit & ~readNotWrite;
        burstRd   <= pendRd;
        burstAddr <= pendAddr;
        if (loadHit) begin
          pendAddr <= addr;
          wrBase   <= addr;
        end
      end
    end
  end

  always_comb begin
    strobe.wrEn = (loadHit & ~readNotWrite) | (~kSlot & wrPend);
    strobe.rdEn = (kSlot & pendRd) | (~kSlot & burstRd);
    wrAddr      = kSlot ? addr : pairMate(wrBase);
    rdAddr      = kSlot ? pendAddr : pairMate(burstAddr);
  end

  // R10
  phase_alt_chk: assert property (@(posedge clk2x) disable iff (!rstN)
    !loadN || loadN |=> (phase != $past(phase)));

  // R2
  no_load_no_write_chk: assert property (@(posedge clk2x) disable iff (!rstN)
    (kSlot && loadN) |-> !strobe.wrEn);

  // R4
  wr_beat1_chk: assert property (@(posedge clk2x) disable iff (!rstN)
    (strobe.wrEn && !kSlot) |->
      ($past(!loadN && !readNotWrite) && (wrAddr == ($past(addr) ^ AW'(1)))));

  // R7
  rd_latency_chk: assert property (@(posedge clk2x) disable iff (!rstN)
    (strobe.rdEn && kSlot) |-> $past(!loadN && readNotWrite, 2));

  // R6
  rd_pair_chk: assert property (@(posedge clk2x) disable iff (!rstN)
    (strobe.rdEn && kSlot) |=> (strobe.rdEn && (rdAddr == ($past(rdAddr) ^ AW'(1)))));

endmodule

// File: rtl/burst2_datapath.sv
module burst2_datapath
  import burst2_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LANES = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * LANE_W
) (
  input  logic             clk2x,
  input  logic             rstN,
  input  beatStrobe_t      strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic             kSlot,
  input  logic [DW-1:0]    dqIn,
  input  logic [LANES-1:0] byteWeN,
  output logic [DW-1:0]    dqOut,
  output logic             dqOe
);

  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] laneQ;

    always_ff @(posedge clk2x) begin
      if (strobe.wrEn && !byteWeN[ln])
        store[wrAddr] <= dqIn[ln*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk2x or negedge rstN) begin
      if (!rstN)            laneQ <= '0;
      else if (strobe.rdEn) laneQ <= store[rdAddr];
    end

    assign dqOut[ln*LANE_W +: LANE_W] = laneQ;

    // R5
    lane_store_chk: assert property (@(posedge clk2x) disable iff (!rstN)
      (strobe.wrEn && !byteWeN[ln]) |=>
        (store[$past(wrAddr)] == $past(dqIn[ln*LANE_W +: LANE_W])));
  end

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) dqOe <= 1'b0;
    else       dqOe <= strobe.rdEn;
  end

  // R8
  oe_rise_chk: assert property (@(posedge clk2x) disable iff (!rstN)
    $rose(dqOe) |-> !kSlot);

  // R8
  oe_fall_chk: assert property (@(posedge clk2x) disable iff (!rstN)
    $fell(dqOe) |-> !kSlot);

endmodule

// File: rtl/burst2_ddr_sram.sv
module burst2_ddr_sram
  import burst2_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LANES = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * LANE_W
) (
  input  logic             clk2x,
  input  logic             rstN,
  input  logic             loadN,
  input  logic             readNotWrite,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    dqIn,
  input  logic [LANES-1:0] byteWeN,
  output logic [DW-1:0]    dqOut,
  output logic             dqOe
);

  beatStrobe_t   strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  logic          kSlot;

  burst2_ctrl #(.AW(AW)) uCtrl (
    .clk2x        (clk2x),
    .rstN         (rstN),
    .loadN        (loadN),
    .readNotWrite (readNotWrite),
    .addr         (addr),
    .strobe       (strobe),
    .wrAddr       (wrAddr),
    .rdAddr       (rdAddr),
    .kSlot        (kSlot)
  );

  burst2_datapath #(.DEPTH(DEPTH), .LANES(LANES)) uData (
    .clk2x   (clk2x),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .kSlot   (kSlot),
    .dqIn    (dqIn),
    .byteWeN (byteWeN),
    .dqOut   (dqOut),
    .dqOe    (dqOe)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk2x) disable iff (!rstN)
    $rose(rstN) |-> !dqOe);

endmodule

// File: tb/sim_burst2_ddr_sram.sv
`timescale 1ns/1ps
module sim_burst2_ddr_sram;

  logic        clk2x = 1'b0;
  logic        rstN  = 1'b0;
  logic        loadN = 1'b1;
  logic        readNotWrite = 1'b0;
  logic [7:0]  addr  = '0;
  logic [17:0] dqIn  = '0;
  logic [1:0]  byteWeN = 2'b11;
  logic [17:0] dqOut;
  logic        dqOe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk2x = ~clk2x;

  burst2_ddr_sram u0 (
    .clk2x(clk2x), .rstN(rstN), .loadN(loadN), .readNotWrite(readNotWrite),
    .addr(addr), .dqIn(dqIn), .byteWeN(byteWeN), .dqOut(dqOut), .dqOe(dqOe)
  );

  typedef struct packed {
    logic        ld;
    logic        rd;
    logic [7:0]  a;
    logic [17:0] d0;
    logic [1:0]  b0;
    logic [17:0] d1;
    logic [1:0]  b1;
    logic [17:0] e0;
    logic [17:0] e1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R3 R4 write pair 0x10/0x11
    '{1'b1, 1'b0, 8'h10, 18'h12345, 2'b00, 18'h0ABCD, 2'b00, 18'h0, 18'h0},
    // R6 odd start: beat0 -> 0x21, beat1 -> 0x20
    '{1'b1, 1'b0, 8'h21, 18'h11111, 2'b00, 18'h22222, 2'b00, 18'h0, 18'h0},
    // R7 read
    '{1'b1, 1'b1, 8'h10, 18'h3FFFF, 2'b00, 18'h3FFFF, 2'b00, 18'h12345, 18'h0ABCD},
    // R9 back-to-back read
    '{1'b1, 1'b1, 8'h21, 18'h0, 2'b00, 18'h0, 2'b00, 18'h11111, 18'h22222},
    // R5 beat0 high byte masked, beat1 low byte masked
    '{1'b1, 1'b0, 8'h10, 18'h3FFFF, 2'b10, 18'h00000, 2'b01, 18'h0, 18'h0},
    // R9 R6 read right after write, odd start
    '{1'b1, 1'b1, 8'h11, 18'h0, 2'b00, 18'h0, 2'b00, 18'h001CD, 18'h123FF},
    // R2 no load with write direction
    '{1'b0, 1'b0, 8'h10, 18'h00000, 2'b00, 18'h00000, 2'b00, 18'h0, 18'h0},
    '{1'b1, 1'b1, 8'h10, 18'h0, 2'b00, 18'h0, 2'b00, 18'h123FF, 18'h001CD},
    // R5 both beats fully masked
    '{1'b1, 1'b0, 8'h20, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11, 18'h0, 18'h0},
    '{1'b1, 1'b1, 8'h20, 18'h0, 2'b00, 18'h0, 2'b00, 18'h22222, 18'h11111},
    // R2 no load with read direction
    '{1'b0, 1'b1, 8'h10, 18'h0, 2'b00, 18'h0, 2'b00, 18'h0, 18'h0},
    '{1'b1, 1'b1, 8'h21, 18'h0, 2'b00, 18'h0, 2'b00, 18'h11111, 18'h22222}
  };

  task automatic checkVal(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
    end
  endtask

  // Checks one observed beat: enable, and data when a read is expected.
  task automatic checkBeat(input string req, input bit expOe, input logic [17:0] expData);
    checkVal({req, " oe"}, {17'b0, dqOe}, {17'b0, expOe});
    if (expOe) checkVal({req, " data"}, dqOut, expData);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t prev;
    vec_t cur;
    repeat (3) @(negedge clk2x);
    // R1 reset state
    checkVal("R1 reset", {17'b0, dqOe}, 18'h0);
    rstN = 1'b1;   // R10: next rising edge is a K edge

    for (int i = 0; i <= NV; i++) begin
      cur = (i < NV) ? VECS[i] : '0;
      loadN        = ~cur.ld;
      readNotWrite = cur.rd;
      addr         = cur.a;
      dqIn         = cur.d0;
      byteWeN      = cur.b0;
      @(negedge clk2x);
      if (i > 0) checkBeat("R7 beat0", prev.ld && prev.rd, prev.e0);
      else       checkBeat("R8 idle", 1'b0, 18'h0);
      loadN   = 1'b1;
      dqIn    = cur.d1;
      byteWeN = cur.b1;
      @(negedge clk2x);
      if (i > 0) checkBeat("R6 beat1", prev.ld && prev.rd, prev.e1);
      else       checkBeat("R8 idle", 1'b0, 18'h0);
      prev = cur;
    end

    // R1: reset between a read load and its data cancels the read
    loadN = 1'b0; readNotWrite = 1'b1; addr = 8'h10;
    @(negedge clk2x);
    loadN = 1'b1;
    @(negedge clk2x);
    rstN = 1'b0;
    @(negedge clk2x);
    checkBeat("R1 cancel", 1'b0, 18'h0);
    @(negedge clk2x);
    checkBeat("R1 cancel", 1'b0, 18'h0);
    rstN = 1'b1;

    // R10: after the new release the first edge is K again; array is kept
    loadN = 1'b0; readNotWrite = 1'b1; addr = 8'h10;
    @(negedge clk2x);
    loadN = 1'b1; readNotWrite = 1'b0;
    @(negedge clk2x);
    checkBeat("R10 wait", 1'b0, 18'h0);
    @(negedge clk2x);
    checkBeat("R10 beat0", 1'b1, 18'h123FF);
    @(negedge clk2x);
    checkBeat("R10 beat1", 1'b1, 18'h001CD);
    @(negedge clk2x);
    checkBeat("R8 drop", 1'b0, 18'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule